// File: doc/BRIEF.md
# Wrapping Word Copy Engine

This block moves a burst of 16-bit words from a 16 KB source buffer into one 4 KB bank of a byte-organised wave memory. A single start strobe launches the burst with a word count, the current source-pointer register, the current destination-pointer register and a bank number. The source register holds a byte address. The destination register counts in units of four bytes. Each pointer wraps inside its own region, so a burst that runs off the top of either region continues from offset zero.

On every accepted start the block also returns updated values for both pointer registers, and the owner of those registers writes them back. The source register grows by twice the word count. The destination register grows by half the word count. Both are computed once, at launch, and do not depend on how the copy itself proceeds. One word is read per clock from a source port with one cycle of read latency. Each word is written to the destination port as a 16-bit value covering an even byte address and the byte above it. A one-cycle done pulse closes every burst, including an empty one.

Top module: `word_copy_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, src_rd_en, dst_wr_en, done and reg_upd are all 0.
- R2: If start is sampled high while the block is idle, reg_upd is 1 for exactly the next cycle. In that cycle src_reg_next = (src_reg + 2*word_count) mod 2^16 and dst_reg_next = (dst_reg + floor(word_count/2)) mod 2^16.
- R3: The first source read of a burst uses byte address src_reg & 0x3FFE, given on the 14-bit src_rd_addr.
- R4: dst_wr_addr is 16 bits: bank_sel as sampled with start in bits [15:12], and a byte offset in bits [11:0]. The first offset of a burst is (dst_reg * 4) & 0xFFE. Changing bank_sel after start has no effect on that burst.
- R5: Each later source read address is the previous one plus 2, wrapping from 0x3FFE to 0x0000.
- R6: Each later destination offset is the previous one plus 2, wrapping from 0xFFE to 0x000 while bits [15:12] stay at the burst's bank.
- R7: A burst of N words drives src_rd_en for N consecutive cycles, starting the cycle after start is sampled. Word k is written with dst_wr_en two cycles after its read cycle. dst_wr_data equals the src_rd_data returned one cycle after the read, unchanged. Bits [7:0] go to the even byte and bits [15:8] to the odd byte.
- R8: With N > 0 and start sampled at clock edge E0, done is 1 only in the cycle after edge E(N+2), which is one cycle after the last write.
- R9: A word count of 0 produces no reads and no writes. It still pulses reg_upd, and done is 1 only in the cycle after edge E1.
- R10: A start that arrives while a burst is still reading, writing or finishing is ignored: it causes no reg_upd pulse and no extra reads or writes.
- R11: A start sampled in the cycle in which done is 1 is accepted as a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, sampled at a rising edge |
| word_count | input | 16 | Number of 16-bit words to copy |
| src_reg | input | 16 | Current source pointer register (byte address) |
| dst_reg | input | 16 | Current destination pointer register (4-byte units) |
| bank_sel | input | 4 | Destination bank, sampled with start |
| src_rd_en | output | 1 | Source read request |
| src_rd_addr | output | 14 | Source byte address, always even |
| src_rd_data | input | 16 | Source word, valid one cycle after the request |
| dst_wr_en | output | 1 | Destination write strobe for one word (two bytes) |
| dst_wr_addr | output | 16 | Destination byte address: bank and even offset |
| dst_wr_data | output | 16 | Word to write; low byte to the even address |
| done | output | 1 | One-cycle burst completion pulse |
| reg_upd | output | 1 | One-cycle strobe: write back the two next values |
| src_reg_next | output | 16 | Updated source pointer register |
| dst_reg_next | output | 16 | Updated destination pointer register |

## Verification
The completion pulse of one burst and the acceptance of the next can fall in the same cycle. The pipeline is empty while done is high, so a start seen then must launch a fresh burst, with its register update and its first read, and must not be dropped as "busy". The bench provokes this by raising start at the same falling edge at which it first sees done. It does this after normal bursts and after an empty one. It then judges the result with the scoreboard: every write of the new burst must match, in order, what the driver queued, and the new burst's reg_upd and done timing must land on the computed cycles.

// File: rtl/wcopy_pkg.sv
package wcopy_pkg;

  // issue-stage state: idle, or one source read per cycle
  typedef enum logic {
    ISS_IDLE = 1'b0,
    ISS_RUN  = 1'b1
  } iss_state_e;

  // tag that travels with each word through the copy pipeline
  typedef struct packed {
    logic vld;
    logic last;
  } word_tag_t;

endpackage

// File: rtl/wcopy_wrap_ptr.sv
module wcopy_wrap_ptr #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-2:0] load_idx,
  input  logic          step,
  output logic [AW-1:0] addr
);

  // word index; the byte address is the index with a zero below it,
  // so natural overflow gives the aligned wrap
  logic [AW-2:0] widx;

  always_ff @(posedge clk) begin
    if (rst) begin
      widx <= '0;
    end else if (load) begin
      widx <= load_idx;
    end else if (step) begin
      widx <= widx + 1'b1;
    end
  end

  assign addr = {widx, 1'b0};

  // R5 / R6: each step moves by one word inside the region
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (addr == $past(addr) + AW'(2)));

endmodule

// File: rtl/wcopy_issue.sv
module wcopy_issue
  import wcopy_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [CNT_W-1:0] count,
  output logic             rd_en,
  output logic             rd_last,
  output logic             zero_hit
);

  iss_state_e       state;
  logic [CNT_W-1:0] remaining;   // reads still to issue after the current one

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ISS_IDLE;
      remaining <= '0;
      rd_last   <= 1'b0;
      zero_hit  <= 1'b0;
    end else if (accept) begin
      zero_hit <= (count == '0);
      if (count == '0) begin
        state   <= ISS_IDLE;
        rd_last <= 1'b0;
      end else begin
        state     <= ISS_RUN;
        remaining <= count - 1'b1;
        rd_last   <= (count == CNT_W'(1));
      end
    end else begin
      zero_hit <= 1'b0;
      if (state == ISS_RUN) begin
        if (remaining == '0) begin
          state   <= ISS_IDLE;
          rd_last <= 1'b0;
        end else begin
          remaining <= remaining - 1'b1;
          rd_last   <= (remaining == CNT_W'(1));
        end
      end
    end
  end

  assign rd_en = (state == ISS_RUN);

  // R7: the last read of a burst is followed by an idle issue stage
  assert_last_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_last) |=> !rd_en);

  // R10: a launch is only taken while no read is being issued
  assert_accept_idle_R10: assert property (@(posedge clk) disable iff (rst)
    accept |-> !rd_en);

endmodule

// File: rtl/wcopy_regupd.sv
module wcopy_regupd #(
  parameter int REG_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [CNT_W-1:0] count,
  input  logic [REG_W-1:0] src_reg,
  input  logic [REG_W-1:0] dst_reg,
  output logic             upd,
  output logic [REG_W-1:0] src_next,
  output logic [REG_W-1:0] dst_next
);

  logic [REG_W-1:0] cnt_ext;
  assign cnt_ext = REG_W'(count);

  always_ff @(posedge clk) begin
    if (rst) begin
      upd      <= 1'b0;
      src_next <= '0;
      dst_next <= '0;
    end else begin
      upd <= accept;
      if (accept) begin
        src_next <= src_reg + (cnt_ext << 1);
        dst_next <= dst_reg + (cnt_ext >> 1);
      end
    end
  end

  // R2: the update strobe never lasts two cycles
  assert_upd_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    upd |=> !upd);

endmodule

// File: rtl/wcopy_wstage.sv
module wcopy_wstage
  import wcopy_pkg::*;
#(
  parameter int DST_OW = 12,
  parameter int BANK_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     accept,
  input  logic [BANK_W-1:0]        bank_in,
  input  logic                     rd_en,
  input  logic                     rd_last,
  input  logic [DST_OW-1:0]        rd_off,
  input  logic [DATA_W-1:0]        rd_data,
  input  logic                     zero_hit,
  output logic                     wr_en,
  output logic [BANK_W+DST_OW-1:0] wr_addr,
  output logic [DATA_W-1:0]        wr_data,
  output logic                     done,
  output logic                     pipe_busy
);

  word_tag_t          s1;        // word whose source data is arriving now
  logic [DST_OW-1:0]  s1_off;
  logic [BANK_W-1:0]  bank_q;
  logic               wr_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q  <= '0;
      s1      <= '0;
      s1_off  <= '0;
      wr_en   <= 1'b0;
      wr_last <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
    end else begin
      if (accept) begin
        bank_q <= bank_in;
      end
      s1.vld  <= rd_en;
      s1.last <= rd_en && rd_last;
      s1_off  <= rd_off;
      wr_en   <= s1.vld;
      wr_last <= s1.last;
      if (s1.vld) begin
        wr_addr <= {bank_q, s1_off};
        wr_data <= rd_data;
      end
      done <= (wr_en && wr_last) || zero_hit;
    end
  end

  assign pipe_busy = s1.vld | wr_en;

  // R4: the bank field is constant across back-to-back writes of a burst
  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |->
      (wr_addr[BANK_W+DST_OW-1:DST_OW] == $past(wr_addr[BANK_W+DST_OW-1:DST_OW])));

endmodule

// File: rtl/word_copy_engine.sv
module word_copy_engine
  import wcopy_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int CNT_W  = 16,
  parameter int SRC_AW = 14,
  parameter int DST_OW = 12,
  parameter int BANK_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [CNT_W-1:0]         word_count,
  input  logic [REG_W-1:0]         src_reg,
  input  logic [REG_W-1:0]         dst_reg,
  input  logic [BANK_W-1:0]        bank_sel,
  output logic                     src_rd_en,
  output logic [SRC_AW-1:0]        src_rd_addr,
  input  logic [DATA_W-1:0]        src_rd_data,
  output logic                     dst_wr_en,
  output logic [BANK_W+DST_OW-1:0] dst_wr_addr,
  output logic [DATA_W-1:0]        dst_wr_data,
  output logic                     done,
  output logic                     reg_upd,
  output logic [REG_W-1:0]         src_reg_next,
  output logic [REG_W-1:0]         dst_reg_next
);

  // destination register counts 4-byte units: its low DST_OW-2 bits
  // become offset bits [DST_OW-1:2]; as a word index that is {bits, 1'b0}
  localparam int SRC_IW = SRC_AW - 1;
  localparam int DST_IW = DST_OW - 1;

  logic              accept;
  logic              busy;
  logic              rd_last;
  logic              zero_hit;
  logic              pipe_busy;
  logic [DST_OW-1:0] dst_off;
  logic [SRC_IW-1:0] src_idx0;
  logic [DST_IW-1:0] dst_idx0;

  assign busy     = src_rd_en | pipe_busy | zero_hit;
  assign accept   = start & ~busy;
  assign src_idx0 = src_reg[SRC_AW-1:1];
  assign dst_idx0 = {dst_reg[DST_OW-3:0], 1'b0};

  wcopy_issue #(.CNT_W(CNT_W)) i_issue (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .count    (word_count),
    .rd_en    (src_rd_en),
    .rd_last  (rd_last),
    .zero_hit (zero_hit)
  );

  wcopy_wrap_ptr #(.AW(SRC_AW)) i_src_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_idx (src_idx0),
    .step     (src_rd_en),
    .addr     (src_rd_addr)
  );

  wcopy_wrap_ptr #(.AW(DST_OW)) i_dst_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_idx (dst_idx0),
    .step     (src_rd_en),
    .addr     (dst_off)
  );

  wcopy_regupd #(.REG_W(REG_W), .CNT_W(CNT_W)) i_regupd (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .count    (word_count),
    .src_reg  (src_reg),
    .dst_reg  (dst_reg),
    .upd      (reg_upd),
    .src_next (src_reg_next),
    .dst_next (dst_reg_next)
  );

  wcopy_wstage #(.DST_OW(DST_OW), .BANK_W(BANK_W), .DATA_W(DATA_W)) i_wstage (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .bank_in   (bank_sel),
    .rd_en     (src_rd_en),
    .rd_last   (rd_last),
    .rd_off    (dst_off),
    .rd_data   (src_rd_data),
    .zero_hit  (zero_hit),
    .wr_en     (dst_wr_en),
    .wr_addr   (dst_wr_addr),
    .wr_data   (dst_wr_data),
    .done      (done),
    .pipe_busy (pipe_busy)
  );

  // R3: source reads are always word aligned
  assert_rd_even_R3: assert property (@(posedge clk) disable iff (rst)
    src_rd_en |-> !src_rd_addr[0]);

  // R4: destination writes are always word aligned
  assert_wr_even_R4: assert property (@(posedge clk) disable iff (rst)
    dst_wr_en |-> !dst_wr_addr[0]);

  // R7: every read is matched by a write two cycles later
  assert_wr_follows_rd_R7: assert property (@(posedge clk) disable iff (rst)
    $past(src_rd_en, 2) |-> dst_wr_en);

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8 / R10: nothing of a burst is still moving when done is shown
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!dst_wr_en && !src_rd_en));

  // R9: an empty burst finishes on the cycle after its update strobe
  assert_zero_done_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_upd && !src_rd_en) |=> done);

endmodule

// File: tb/test_word_copy_engine.sv
`timescale 1ns/1ps
module test_word_copy_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] word_count = '0;
  logic [15:0] src_reg = '0;
  logic [15:0] dst_reg = '0;
  logic [3:0]  bank_sel = '0;
  logic        src_rd_en;
  logic [13:0] src_rd_addr;
  logic [15:0] src_rd_data = '0;
  logic        dst_wr_en;
  logic [15:0] dst_wr_addr;
  logic [15:0] dst_wr_data;
  logic        done;
  logic        reg_upd;
  logic [15:0] src_reg_next;
  logic [15:0] dst_reg_next;

  int n_checks = 0;
  int n_fail   = 0;
  int n_writes = 0;

  typedef struct {
    logic [15:0] addr;
    logic [15:0] data;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;   // 250 MHz

  word_copy_engine i_word_copy_engine (
    .clk(clk), .rst(rst), .start(start), .word_count(word_count),
    .src_reg(src_reg), .dst_reg(dst_reg), .bank_sel(bank_sel),
    .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
    .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data),
    .done(done), .reg_upd(reg_upd),
    .src_reg_next(src_reg_next), .dst_reg_next(dst_reg_next)
  );

  function automatic logic [15:0] src_word(input logic [13:0] a);
    return {a[13:6], a[7:0]} ^ 16'hA55A;
  endfunction

  // source buffer model with one cycle of read latency
  always @(posedge clk) begin
    if (src_rd_en) src_rd_data <= src_word(src_rd_addr);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on every destination write
  always @(negedge clk) begin
    if (!rst && dst_wr_en) begin
      n_writes++;
      if (sb.size() == 0) begin
        check(1'b0, "R7", "write with nothing expected", dst_wr_addr, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(dst_wr_addr == e.addr, "R4/R6", "write address", dst_wr_addr, e.addr);
        check(dst_wr_data == e.data, "R3/R5/R7", "write data", dst_wr_data, e.data);
      end
    end
  end

  // driver: called at a falling edge; returns at the falling edge where done is seen
  task automatic burst(input logic [15:0] s, input logic [15:0] d, input logic [3:0] b,
                       input logic [15:0] n, input bit idle_first, input bit inject_busy);
    logic [13:0] s0;
    logic [11:0] o0;
    int          exp_cyc;
    int          cyc;
    int          w0;
    bit          was_done;
    if (idle_first) repeat (3) @(negedge clk);
    s0 = s[13:0] & 14'h3FFE;
    o0 = {d[9:0], 2'b00};
    for (int k = 0; k < int'(n); k++) begin
      exp_t e;
      e.addr = {b, o0 + 12'(2 * k)};
      e.data = src_word(s0 + 14'(2 * k));
      sb.push_back(e);
    end
    w0 = n_writes;
    was_done = done;
    start = 1'b1; word_count = n; src_reg = s; dst_reg = d; bank_sel = b;
    @(negedge clk);
    start = 1'b0; bank_sel = ~b; src_reg = 16'h5555; dst_reg = 16'hAAAA;
    check(reg_upd == 1'b1, "R2", "update strobe", reg_upd, 1);
    check(src_reg_next == s + 16'(2 * n), "R2", "source register next", src_reg_next, s + 16'(2 * n));
    check(dst_reg_next == d + (n >> 1), "R2", "destination register next", dst_reg_next, d + (n >> 1));
    if (was_done) check(reg_upd == 1'b1, "R11", "start in done cycle accepted", reg_upd, 1);
    if (n == 0) check(src_rd_en == 1'b0, "R9", "no read for empty burst", src_rd_en, 0);
    exp_cyc = (n == 0) ? 1 : int'(n) + 2;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (inject_busy && cyc == 2) begin
        start = 1'b1; word_count = 16'd3; src_reg = 16'h0100; dst_reg = 16'h0040;
      end
      if (inject_busy && cyc == 3) begin
        start = 1'b0;
        check(reg_upd == 1'b0, "R10", "start while busy gives no update", reg_upd, 0);
      end
      if (done || cyc > exp_cyc + 8) break;
    end
    check(cyc == exp_cyc, (n == 0) ? "R9" : "R8", "done cycle", cyc, exp_cyc);
    check(n_writes - w0 == int'(n), (n == 0) ? "R9" : "R7", "write count", n_writes - w0, n);
    check(sb.size() == 0, "R7", "scoreboard drained at done", sb.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(src_rd_en == 0 && dst_wr_en == 0 && done == 0 && reg_upd == 0,
          "R1", "outputs during reset", {src_rd_en, dst_wr_en, done, reg_upd}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(src_rd_en == 0 && dst_wr_en == 0 && done == 0 && reg_upd == 0,
          "R1", "outputs after reset", {src_rd_en, dst_wr_en, done, reg_upd}, 0);

    burst(16'h0010, 16'h0004, 4'd2, 16'd5, 1, 0);   // plain burst, odd count
    burst(16'hD235, 16'h83FF, 4'd7, 16'd4, 1, 0);   // R6 destination wrap, masking
    burst(16'h7FFC, 16'h0020, 4'd1, 16'd4, 1, 0);   // R5 source wrap
    burst(16'hFFF0, 16'hFFFE, 4'd9, 16'd16, 1, 0);  // R2 register overflow
    burst(16'h1234, 16'h0100, 4'd3, 16'd0, 1, 0);   // R9 empty burst
    burst(16'h0200, 16'h0011, 4'd5, 16'd3, 0, 0);   // R11 back to back
    burst(16'h0300, 16'h0012, 4'd6, 16'd0, 0, 0);   // R11 empty after done
    burst(16'h3FFE, 16'h03FF, 4'd15, 16'd1, 0, 0);  // R11 after empty, both wrap edges
    burst(16'h0400, 16'h0030, 4'd4, 16'd6, 1, 1);   // R10 start while busy
    repeat (6) @(negedge clk);
    check(n_writes == 39, "R10", "total writes", n_writes, 39);
    check(sb.size() == 0, "R10", "no stray writes after busy start", sb.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule